// File: doc/BRIEF.md
# Supply Fault and Error Flag Aggregator

This block collects the global fault conditions of an isolated multi-channel output driver into two small status registers and drives an active-low, open-drain error line. Two supply comparator inputs (undervoltage and missing voltage) each pass a blanking filter counted in system clocks before they can set their flags. A transmission-fault input sets its own flag directly. All three flags are sticky. They start in the error state after reset, so the error line stays pulled low until the host has read both registers.

The block also owns the channel drive register and the output gating. An active-low output-disable input forces every channel off in the same cycle. When it stays low for a parameterised minimum width, it also clears the drive register. Per-channel switch faults and the overtemperature reports of active channels feed the error OR. A status bit tells the host when every channel is off.

Top module: `faultAgg`

## Requirements
- R1: While reset is asserted and right after it, the undervoltage, missing-voltage and transmission-fault flags read 1, the drive register is 0, all channel outputs are 0, and `errPullLow` is 1.
- R2: A supply flag is set only when its comparator input has been high at more than BLANK_CYC consecutive rising clock edges. A shorter high pulse leaves the flag unchanged.
- R3: Once set, a flag stays set after its condition has gone away, until the register holding it is read.
- R4: A read clears a flag only if its condition is absent at that clock edge. If the condition is still present, the flag stays 1.
- R5: `errPullLow` is 1 whenever any of the following is true: any flag is set, any `chanFault` bit is high, or any `otReport` bit is high. With both registers read and no fault present, it is 0.
- R6: `globalReg` holds undervoltage in bit 0, missing voltage in bit 1 and all-off in bit 2, with bits 7:3 zero. `internalReg` holds the transmission-fault flag in bit 0, with bits 7:1 zero.
- R7: A write loads `drvWrData` into the drive register at the clock edge. `drvOut` equals the drive register with the channels in `thermOff` forced to 0.
- R8: While `odisN` is low, `drvOut` is 0 in the same cycle, with no clock edge needed.
- R9: If `odisN` is low for ODIS_MIN or more clocks, the drive register clears. A shorter low pulse leaves it intact, and the outputs return to their previous values.
- R10: While an output-disable pulse longer than ODIS_MIN is in progress, drive writes are ignored.
- R11: The all-off bit is 1 exactly when every channel output is 0. This holds whatever the cause: the drive value, output disable or thermal shutdown.
- R12: `otReport` is `chanOtRaw` masked by the drive register. A channel commanded off always reports 0.
- R13: A high `txFault` sets the transmission-fault flag at the next clock edge, with no blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| uvRaw | input | 1 | Undervoltage comparator output |
| mvRaw | input | 1 | Missing-voltage comparator output |
| txFault | input | 1 | Transmission-fault condition |
| chanFault | input | NCH | Per-channel switch fault conditions |
| chanOtRaw | input | NCH | Per-channel overtemperature sense |
| thermOff | input | NCH | Per-channel thermal shutdown |
| odisN | input | 1 | Active-low output disable |
| drvWrEn | input | 1 | Drive register write strobe |
| drvWrData | input | NCH | Drive register write data |
| rdGlobal | input | 1 | Read strobe of the global error register |
| rdInternal | input | 1 | Read strobe of the internal error register |
| drvOut | output | NCH | Channel on commands |
| otReport | output | NCH | Overtemperature report of active channels |
| globalReg | output | 8 | Global error register read data |
| internalReg | output | 8 | Internal error register read data |
| errPullLow | output | 1 | Pull-down enable of the open-drain error line |

## Verification
The assertions take all inputs as synchronous to `clk`, with the two supply comparators free of metastability. They also take a read strobe as lasting a single cycle, and `thermOff` as settled when the overtemperature relation is checked. The bench changes every input just after a falling edge. It keeps `thermOff` at zero and `odisN` high whenever it looks at overtemperature against the outputs. It times its output-disable pulses in whole clock periods on either side of ODIS_MIN, so the two-stage synchronizer only delays them.

// File: rtl/faultAggPkg.sv
package faultAggPkg;

  // strobes from control to datapath, one clock wide unless noted
  typedef struct packed {
    logic uvCond;      // filtered undervoltage condition (level)
    logic mvCond;      // filtered missing-voltage condition (level)
    logic clrGlobal;   // read of the global error register
    logic clrInternal; // read of the internal error register
    logic clrDrive;    // qualified output disable: hold drive register at zero
    logic loadDrive;   // accepted drive write
  } aggStrobeT;

  localparam int REG_W = 8;

endpackage

// File: rtl/blankFilter.sv
module blankFilter #(
  parameter int BLANK_CYC = 250000
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic condOut
);
  localparam int CW = $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(BLANK_CYC);

  logic [CW-1:0] runCnt;

  // counts consecutive high samples, saturating at the blanking limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (!rawIn) begin
      runCnt <= '0;
    end else if (runCnt != LIMIT) begin
      runCnt <= runCnt + 1'b1;
    end
  end

  // condition counts only while the input is still high past the window
  assign condOut = rawIn && (runCnt == LIMIT);

endmodule

// File: rtl/faultCtrl.sv
module faultCtrl
  import faultAggPkg::*;
#(
  parameter int BLANK_CYC = 250000,
  parameter int ODIS_MIN  = 625
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      uvRaw,
  input  logic      mvRaw,
  input  logic      odisN,
  input  logic      drvWrEn,
  input  logic      rdGlobal,
  input  logic      rdInternal,
  output aggStrobeT stb
);
  localparam int NCMP = 2;
  localparam int OW   = $clog2(ODIS_MIN + 1);
  localparam logic [OW-1:0] ODIS_LIM  = OW'(ODIS_MIN);
  localparam logic [OW-1:0] ODIS_LAST = OW'(ODIS_MIN - 1);

  logic [NCMP-1:0] cmpRaw;
  logic [NCMP-1:0] cmpCond;

  assign cmpRaw = {mvRaw, uvRaw};

  for (genvar g = 0; g < NCMP; g++) begin : gBlank
    blankFilter #(.BLANK_CYC(BLANK_CYC)) uFilt (
      .clk    (clk),
      .rstN   (rstN),
      .rawIn  (cmpRaw[g]),
      .condOut(cmpCond[g])
    );
  end

  // output-disable width qualification on a synchronized copy
  logic odisMeta;
  logic odisSync;
  logic [OW-1:0] lowCnt;
  logic odisQual;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      odisMeta <= 1'b1;
      odisSync <= 1'b1;
    end else begin
      odisMeta <= odisN;
      odisSync <= odisMeta;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (odisSync) begin
      lowCnt <= '0;
    end else if (lowCnt != ODIS_LIM) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  // true from the clock that completes the minimum width onward
  assign odisQual = !odisSync && (lowCnt >= ODIS_LAST);

  always_comb begin
    stb.uvCond      = cmpCond[0];
    stb.mvCond      = cmpCond[1];
    stb.clrGlobal   = rdGlobal;
    stb.clrInternal = rdInternal;
    stb.clrDrive    = odisQual;
    stb.loadDrive   = drvWrEn && !odisQual;
  end

endmodule

// File: rtl/faultData.sv
module faultData
  import faultAggPkg::*;
#(
  parameter int NCH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  aggStrobeT        stb,
  input  logic             txFault,
  input  logic [NCH-1:0]   chanFault,
  input  logic [NCH-1:0]   chanOtRaw,
  input  logic [NCH-1:0]   thermOff,
  input  logic             odisN,
  input  logic [NCH-1:0]   drvWrData,
  output logic [NCH-1:0]   drvOut,
  output logic [NCH-1:0]   otReport,
  output logic [REG_W-1:0] globalReg,
  output logic [REG_W-1:0] internalReg,
  output logic             errPullLow
);
  logic uvFlag;
  logic mvFlag;
  logic teFlag;
  logic [NCH-1:0] drvReg;
  logic allOff;

  // sticky flags, preset to the error state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      uvFlag <= 1'b1;
      mvFlag <= 1'b1;
      teFlag <= 1'b1;
    end else begin
      uvFlag <= stb.uvCond | (uvFlag & ~stb.clrGlobal);
      mvFlag <= stb.mvCond | (mvFlag & ~stb.clrGlobal);
      teFlag <= txFault    | (teFlag & ~stb.clrInternal);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drvReg <= '0;
    end else if (stb.clrDrive) begin
      drvReg <= '0;
    end else if (stb.loadDrive) begin
      drvReg <= drvWrData;
    end
  end

  // output disable acts without a clock edge
  assign drvOut   = drvReg & ~thermOff & {NCH{odisN}};
  assign allOff   = ~|drvOut;
  assign otReport = chanOtRaw & drvReg;

  always_comb begin
    globalReg      = '0;
    globalReg[0]   = uvFlag;
    globalReg[1]   = mvFlag;
    globalReg[2]   = allOff;
    internalReg    = '0;
    internalReg[0] = teFlag;
  end

  assign errPullLow = uvFlag | mvFlag | teFlag | (|chanFault) | (|otReport);

endmodule

// File: rtl/faultAgg.sv
module faultAgg
  import faultAggPkg::*;
#(
  parameter int NCH       = 8,
  parameter int BLANK_CYC = 250000,
  parameter int ODIS_MIN  = 625
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           uvRaw,
  input  logic           mvRaw,
  input  logic           txFault,
  input  logic [NCH-1:0] chanFault,
  input  logic [NCH-1:0] chanOtRaw,
  input  logic [NCH-1:0] thermOff,
  input  logic           odisN,
  input  logic           drvWrEn,
  input  logic [NCH-1:0] drvWrData,
  input  logic           rdGlobal,
  input  logic           rdInternal,
  output logic [NCH-1:0] drvOut,
  output logic [NCH-1:0] otReport,
  output logic [7:0]     globalReg,
  output logic [7:0]     internalReg,
  output logic           errPullLow
);
  aggStrobeT stb;

  faultCtrl #(.BLANK_CYC(BLANK_CYC), .ODIS_MIN(ODIS_MIN)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .uvRaw     (uvRaw),
    .mvRaw     (mvRaw),
    .odisN     (odisN),
    .drvWrEn   (drvWrEn),
    .rdGlobal  (rdGlobal),
    .rdInternal(rdInternal),
    .stb       (stb)
  );

  faultData #(.NCH(NCH)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .txFault    (txFault),
    .chanFault  (chanFault),
    .chanOtRaw  (chanOtRaw),
    .thermOff   (thermOff),
    .odisN      (odisN),
    .drvWrData  (drvWrData),
    .drvOut     (drvOut),
    .otReport   (otReport),
    .globalReg  (globalReg),
    .internalReg(internalReg),
    .errPullLow (errPullLow)
  );

endmodule

// File: rtl/faultAggChk.sv
module faultAggChk #(
  parameter int NCH       = 8,
  parameter int BLANK_CYC = 250000
) (
  input logic           clk,
  input logic           rstN,
  input logic           uvRaw,
  input logic           odisN,
  input logic           rdGlobal,
  input logic           rdInternal,
  input logic [NCH-1:0] thermOff,
  input logic [NCH-1:0] drvOut,
  input logic [NCH-1:0] otReport,
  input logic [7:0]     globalReg,
  input logic [7:0]     internalReg,
  input logic           errPullLow
);
  int unsigned uvRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) uvRun <= 0;
    else if (!uvRaw) uvRun <= 0;
    else if (uvRun < BLANK_CYC) uvRun <= uvRun + 1;
  end

  AST_UV_BLANKED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(globalReg[0]) |-> $past(uvRaw && (uvRun >= BLANK_CYC))); // R2

  AST_UV_HELD_TILL_READ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(globalReg[0]) |-> $past(rdGlobal)); // R3

  AST_TE_HELD_TILL_READ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(internalReg[0]) |-> $past(rdInternal)); // R3

  AST_ERR_ON_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (globalReg[0] || globalReg[1] || internalReg[0]) |-> errPullLow); // R5

  AST_ODIS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !odisN |-> (drvOut == '0)); // R8

  AST_OT_ACTIVE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (odisN && (thermOff == '0)) |-> ((otReport & ~drvOut) == '0)); // R12

endmodule

bind faultAgg faultAggChk #(.NCH(NCH), .BLANK_CYC(BLANK_CYC)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .uvRaw      (uvRaw),
  .odisN      (odisN),
  .rdGlobal   (rdGlobal),
  .rdInternal (rdInternal),
  .thermOff   (thermOff),
  .drvOut     (drvOut),
  .otReport   (otReport),
  .globalReg  (globalReg),
  .internalReg(internalReg),
  .errPullLow (errPullLow)
);

// File: tb/sim_faultAgg.sv
module sim_faultAgg;
  localparam int NCH   = 8;
  localparam int BLANK = 6;
  localparam int OMIN  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic uvRaw = 0, mvRaw = 0, txFault = 0, odisN = 1;
  logic drvWrEn = 0, rdGlobal = 0, rdInternal = 0;
  logic [NCH-1:0] chanFault = '0, chanOtRaw = '0, thermOff = '0, drvWrData = '0;
  logic [NCH-1:0] drvOut, otReport;
  logic [7:0] globalReg, internalReg;
  logic errPullLow;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #4 clk = ~clk; // 125 MHz

  faultAgg #(.NCH(NCH), .BLANK_CYC(BLANK), .ODIS_MIN(OMIN)) u0 (
    .clk(clk), .rstN(rstN), .uvRaw(uvRaw), .mvRaw(mvRaw), .txFault(txFault),
    .chanFault(chanFault), .chanOtRaw(chanOtRaw), .thermOff(thermOff),
    .odisN(odisN), .drvWrEn(drvWrEn), .drvWrData(drvWrData),
    .rdGlobal(rdGlobal), .rdInternal(rdInternal), .drvOut(drvOut),
    .otReport(otReport), .globalReg(globalReg), .internalReg(internalReg),
    .errPullLow(errPullLow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=<50000", cycles);
      finishRun();
    end
  end

  task automatic readGlobal();
    rdGlobal = 1; step(); rdGlobal = 0;
  endtask

  task automatic readInternal();
    rdInternal = 1; step(); rdInternal = 0;
  endtask

  task automatic writeDrive(input logic [NCH-1:0] v);
    drvWrData = v; drvWrEn = 1; step(); drvWrEn = 0;
  endtask

  initial begin
    step(3);
    // R1 reset presets (R6 layout: uv bit0, mv bit1, alloff bit2, te bit0)
    chk("R1 global in reset", globalReg, 8'h07);
    chk("R1 internal in reset", internalReg, 8'h01);
    chk("R1 err in reset", errPullLow, 1);
    chk("R1 outputs in reset", drvOut, 0);
    rstN = 1;
    step(2);
    chk("R1 global after reset", globalReg, 8'h07);
    chk("R1 err after reset", errPullLow, 1);

    // R5 err released only after both registers read
    readGlobal();
    chk("R6 global after read", globalReg, 8'h04);
    chk("R5 err held by te flag", errPullLow, 1);
    readInternal();
    chk("R6 internal after read", internalReg, 8'h00);
    chk("R5 err released", errPullLow, 0);

    // R2 blanking boundary
    uvRaw = 1; step(BLANK); uvRaw = 0; step();
    chk("R2 short uv pulse ignored", globalReg[0], 0);
    uvRaw = 1; step(BLANK + 1); uvRaw = 0; step();
    chk("R2 uv flag set", globalReg[0], 1);
    step(4);
    chk("R3 uv flag sticky", globalReg[0], 1);
    chk("R5 err on uv", errPullLow, 1);
    readGlobal();
    chk("R4 uv cleared on read", globalReg[0], 0);
    chk("R5 err released after uv", errPullLow, 0);

    // R4 read while condition present
    uvRaw = 1; step(BLANK + 3);
    readGlobal();
    chk("R4 uv re-set while present", globalReg[0], 1);
    uvRaw = 0; step();
    readGlobal();
    chk("R4 uv cleared once gone", globalReg[0], 0);

    mvRaw = 1; step(BLANK); mvRaw = 0; step();
    chk("R2 short mv pulse ignored", globalReg[1], 0);
    mvRaw = 1; step(BLANK + 1); mvRaw = 0; step();
    chk("R2 mv flag set", globalReg[1], 1);
    readGlobal();
    chk("R3 mv cleared by read", globalReg[1], 0);

    // R13 transmission fault
    txFault = 1; step(); txFault = 0;
    chk("R13 te flag set next clock", internalReg[0], 1);
    step(3);
    chk("R3 te flag sticky", internalReg[0], 1);
    readGlobal();
    chk("R3 te not cleared by global read", internalReg[0], 1);
    readInternal();
    chk("R13 te cleared", internalReg[0], 0);

    // R5 per-channel fault feeds err directly
    chanFault = 8'h10; #1;
    chk("R5 err on channel fault", errPullLow, 1);
    chanFault = 8'h00; #1;
    chk("R5 err after channel fault gone", errPullLow, 0);

    // R7 R11 R12 sweep over all drive patterns
    for (int v = 0; v < 256; v++) begin
      logic [7:0] dv, th, ot, expOut, expOt;
      dv = 8'(v);
      th = 8'((v * 37) & 255);
      ot = ~8'(v >> 1);
      thermOff = th;
      chanOtRaw = ot;
      writeDrive(dv);
      expOut = dv & ~th;
      expOt = ot & dv;
      chk("R7 drive output", drvOut, expOut);
      chk("R11 all-off bit", globalReg[2], (expOut == 0));
      chk("R12 ot report", otReport, expOt);
      chk("R5 err from ot", errPullLow, (expOt != 0));
    end
    thermOff = '0;
    chanOtRaw = '0;

    // R8 R9 output disable
    writeDrive(8'hA5);
    chk("R7 drive A5", drvOut, 8'hA5);
    odisN = 0; #1;
    chk("R8 immediate off", drvOut, 0);
    chk("R11 all-off on disable", globalReg[2], 1);
    step(OMIN - 1); odisN = 1; step(4);
    chk("R9 short disable keeps drive", drvOut, 8'hA5);
    odisN = 0; step(OMIN); odisN = 1; step(4);
    chk("R9 long disable clears drive", drvOut, 0);

    // R10 writes ignored during qualified disable
    writeDrive(8'h3C);
    odisN = 0; step(10);
    writeDrive(8'hFF);
    step(1); odisN = 1; step(4);
    chk("R10 write ignored during disable", drvOut, 0);
    writeDrive(8'h3C);
    chk("R7 write after disable", drvOut, 8'h3C);

    // R11 thermal shutdown of all channels
    writeDrive(8'hFF);
    thermOff = 8'hFF; #1;
    chk("R11 all channels thermal off", globalReg[2], 1);
    thermOff = 8'h7F; #1;
    chk("R11 one channel left on", globalReg[2], 0);
    chk("R7 only channel 7 on", drvOut, 8'h80);

    finishRun();
  end

endmodule